// File: doc/BRIEF.md
# Cross-Clock Sample FIFO with Pointer-Phase Controller

This block carries a continuous stream of samples from a forwarded data clock into the converter clock. The two clocks run at the same rate, but their phase relation is not known in advance. An eight-entry FIFO sits between them. The write pointer is Gray coded and passed through a two-flop synchronizer, and the read side compares that pointer with its own read pointer. The difference is the FIFO delay in converter-clock cycles, and the block reports it on `fifoDelay`.

A controller in the converter domain keeps that distance near the middle of the FIFO. Its input is the error between the measured delay and half the depth. It sums the last four errors and compares the magnitude of the sum with a programmable threshold, so one noisy sample does not trigger any action. There are three operating modes:

- **Manual:** software moves the read pointer one step at a time.
- **Surveillance:** a limit violation raises a sticky interrupt.
- **Automatic:** the controller corrects the read pointer itself, but only while `alignOk` says the stream is idle or may be realigned. Otherwise it raises the interrupt and leaves the stream intact.

No samples are read until a calibration request recentres the read pointer. A bypass setting routes the input sample straight to the output and reports zero delay.

Top module: `xclk_align_fifo`

## Requirements
- R1: After reset `rdValid`, `irq`, `calDone` and `fifoDelay` are all 0.
- R2: `rdValid` stays 0 until a `calibReq` pulse with bypass off. `calDone` is 1 from the next `rdClk` edge. `fifoDelay` then settles at 4, which is half the depth. `fifoDelay` is the synchronized write pointer minus the read pointer, limited to 8.
- R3: While calibrated and with no pointer step, every written sample appears on `rdData` exactly once and in write order.
- R4: In manual mode (`cfgMode` 0 or 3), a one-cycle `manualStep` moves the read pointer:
  - with `manualDir`=1 it skips one sample and lowers `fifoDelay` by 1;
  - with `manualDir`=0 it repeats one sample and raises `fifoDelay` by 1.
  Manual mode never sets `irq`.
- R5: A violation exists only when the magnitude of the sum of the last four values of (`fifoDelay` − 4) exceeds 4 × `cfgThresh`. Without a violation, no mode takes any action.
- R6: In surveillance mode (`cfgMode` 1), a violation sets `irq` and leaves the read pointer and the stream untouched. `irq` stays set until an `irqClr` pulse.
- R7: In automatic mode (`cfgMode` 2) with `alignOk`=1, each violation moves the read pointer one step toward the centre and restarts the average. This repeats until `fifoDelay` is back inside the threshold, and `irq` is not set.
- R8: In automatic mode with `alignOk`=0, a violation sets `irq`. No step is taken, so no sample is dropped or repeated.
- R9: With `cfgBypass`=1, `rdData` equals `wrData`, `rdValid` is 1, `fifoDelay` reads 0 and `calDone` is cleared. After bypass ends, `rdValid` stays 0 until the next calibration.
- R10: A calibration request at any time recentres the FIFO, so `fifoDelay` returns to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Forwarded data clock |
| wrRstN | input | 1 | Active-low reset, write domain |
| wrData | input | DW | Sample written on every `wrClk` edge |
| rdClk | input | 1 | Converter clock |
| rdRstN | input | 1 | Active-low reset, read domain |
| cfgMode | input | 2 | 0/3 manual, 1 surveillance, 2 automatic |
| cfgBypass | input | 1 | Pass `wrData` straight to `rdData` |
| cfgThresh | input | THR_W | Averaged error threshold |
| calibReq | input | 1 | One-cycle recentre request |
| manualStep | input | 1 | One-cycle manual pointer step |
| manualDir | input | 1 | 1 skip a sample, 0 repeat a sample |
| alignOk | input | 1 | Stream idle, so automatic steps are allowed |
| irqClr | input | 1 | Clears `irq` |
| rdData | output | DW | Sample in the converter domain |
| rdValid | output | 1 | `rdData` carries a sample |
| irq | output | 1 | Sticky violation interrupt |
| calDone | output | 1 | FIFO has been calibrated |
| fifoDelay | output | $clog2(2**AW+1) | Current FIFO delay in `rdClk` cycles |

## Verification
Some results appear one `rdClk` edge after the request, and the bench samples those at the falling edge that follows:

- `calDone` after a calibration request;
- `fifoDelay` = 0 and `calDone` = 0 after bypass is set.

A manual step changes `rdData` two edges after the pulse is taken. So the bench compares `rdData` at the falling edge of the pulse with its value four falling edges later, and expects a difference of 5 for a skip, 3 for a repeat and 4 for no step.

`fifoDelay` and `irq` depend on the synchronizer and the four-entry average. They are checked only after a settle window of at least eight cycles, which is longer than the worst-case path.

The scoreboard matches every output sample against a queue filled by the write-side driver. It resynchronises only after intentional steps.

// File: rtl/xclk_align_pkg.sv
package xclk_align_pkg;

  typedef enum logic [1:0] {
    MODE_MANUAL = 2'd0,
    MODE_WATCH  = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_SPARE  = 2'd3
  } modeT;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic run;       // advance the read pointer every cycle
    logic calLoad;   // recentre the read pointer
    logic stepHold;  // repeat one sample
    logic stepSkip;  // skip one sample
  } ptrCmdT;

endpackage

// File: rtl/xclk_align_sync.sv
module xclk_align_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/xclk_align_path.sv
module xclk_align_path
  import xclk_align_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH      = 1 << AW,
  localparam int PW         = AW + 1,
  localparam int HALF       = DEPTH / 2
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  ptrCmdT        cmd,
  output logic [DW-1:0] rdDataQ,
  output logic          rdValidQ,
  output logic [PW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, wrPtrNext, wrGray, rdGraySync, wrBinSync, rdPtr, rdStep;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain: one sample per edge, Gray copy of the pointer
  assign wrPtrNext = wrPtr + 1'b1;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    mem[wrPtr[AW-1:0]] <= wrData;
  end

  // crossing into the converter domain
  xclk_align_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_wrSync (
    .clk (rdClk),
    .rstN(rdRstN),
    .din (wrGray),
    .dout(rdGraySync)
  );

  assign wrBinSync = grayToBin(rdGraySync);
  assign occ       = wrBinSync - rdPtr;

  always_comb begin
    if (cmd.stepHold)      rdStep = '0;
    else if (cmd.stepSkip) rdStep = PW'(2);
    else                   rdStep = PW'(1);
  end

  // read domain
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr    <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (cmd.calLoad)  rdPtr <= wrBinSync - PW'(HALF) + PW'(1);
      else if (cmd.run) rdPtr <= rdPtr + rdStep;
      rdValidQ <= cmd.run && !cmd.calLoad;
      if (cmd.run) rdDataQ <= mem[rdPtr[AW-1:0]];
    end
  end
endmodule

// File: rtl/xclk_align_ctrl.sv
module xclk_align_ctrl
  import xclk_align_pkg::*;
#(
  parameter int AW        = 3,
  parameter int AVG_LOG   = 2,
  parameter int THR_W     = 4,
  localparam int DEPTH    = 1 << AW,
  localparam int PW       = AW + 1,
  localparam int HALF     = DEPTH / 2,
  localparam int EW       = PW + 1,
  localparam int AVG_LEN  = 1 << AVG_LOG,
  localparam int SW       = EW + AVG_LOG,
  localparam int CW       = SW + THR_W + AVG_LOG,
  localparam int DLW      = $clog2(DEPTH + 1)
) (
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgBypass,
  input  logic [THR_W-1:0] cfgThresh,
  input  logic             calibReq,
  input  logic             manualStep,
  input  logic             manualDir,
  input  logic             alignOk,
  input  logic             irqClr,
  input  logic [PW-1:0]    occ,
  output ptrCmdT           cmd,
  output logic             irq,
  output logic             calDone,
  output logic [DLW-1:0]   fifoDelay
);
  modeT modeNow;
  logic active, violation, sumNeg, autoFix, manualFix, raise, flush;
  logic signed [EW-1:0] errNow;
  logic signed [EW-1:0] hist [AVG_LEN];
  logic [SW-1:0] sumAcc, sumMag;

  assign modeNow = modeT'(cfgMode);
  assign active  = calDone && !cfgBypass;
  assign errNow  = $signed({1'b0, occ}) - $signed(EW'(HALF));

  // moving sum of the last AVG_LEN errors
  always_comb begin
    sumAcc = '0;
    for (int i = 0; i < AVG_LEN; i++)
      sumAcc = sumAcc + {{(SW-EW){hist[i][EW-1]}}, hist[i]};
  end

  assign sumNeg    = sumAcc[SW-1];
  assign sumMag    = sumNeg ? (~sumAcc + 1'b1) : sumAcc;
  assign violation = active && (CW'(sumMag) > CW'({cfgThresh, {AVG_LOG{1'b0}}}));

  assign autoFix   = violation && (modeNow == MODE_AUTO) && alignOk;
  assign raise     = violation && ((modeNow == MODE_WATCH) ||
                                   ((modeNow == MODE_AUTO) && !alignOk));
  assign manualFix = active && manualStep &&
                     ((modeNow == MODE_MANUAL) || (modeNow == MODE_SPARE));
  assign flush     = !active || calibReq || autoFix || manualFix;

  always_comb begin
    cmd          = '0;
    cmd.run      = active;
    cmd.calLoad  = calibReq && !cfgBypass;
    cmd.stepHold = (autoFix && sumNeg)  || (manualFix && !manualDir);
    cmd.stepSkip = (autoFix && !sumNeg) || (manualFix && manualDir);
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      for (int i = 0; i < AVG_LEN; i++) hist[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < AVG_LEN; i++) hist[i] <= '0;
    end else begin
      hist[0] <= errNow;
      for (int i = 1; i < AVG_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      calDone   <= 1'b0;
      irq       <= 1'b0;
      fifoDelay <= '0;
    end else begin
      if (cfgBypass)     calDone <= 1'b0;
      else if (calibReq) calDone <= 1'b1;

      if (raise)       irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;

      if (!active)                 fifoDelay <= '0;
      else if (occ > PW'(DEPTH))   fifoDelay <= DLW'(DEPTH);
      else                         fifoDelay <= DLW'(occ);
    end
  end
endmodule

// File: rtl/xclk_align_fifo.sv
module xclk_align_fifo
  import xclk_align_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2,
  parameter int AVG_LOG     = 2,
  parameter int THR_W       = 4,
  localparam int PW         = AW + 1,
  localparam int DLW        = $clog2((1 << AW) + 1)
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic [DW-1:0]    wrData,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgBypass,
  input  logic [THR_W-1:0] cfgThresh,
  input  logic             calibReq,
  input  logic             manualStep,
  input  logic             manualDir,
  input  logic             alignOk,
  input  logic             irqClr,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic             irq,
  output logic             calDone,
  output logic [DLW-1:0]   fifoDelay
);
  ptrCmdT        cmd;
  logic [DW-1:0] rdDataQ;
  logic          rdValidQ;
  logic [PW-1:0] occ;

  xclk_align_path #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) i_path (
    .wrClk   (wrClk),
    .wrRstN  (wrRstN),
    .wrData  (wrData),
    .rdClk   (rdClk),
    .rdRstN  (rdRstN),
    .cmd     (cmd),
    .rdDataQ (rdDataQ),
    .rdValidQ(rdValidQ),
    .occ     (occ)
  );

  xclk_align_ctrl #(.AW(AW), .AVG_LOG(AVG_LOG), .THR_W(THR_W)) i_ctrl (
    .rdClk     (rdClk),
    .rdRstN    (rdRstN),
    .cfgMode   (cfgMode),
    .cfgBypass (cfgBypass),
    .cfgThresh (cfgThresh),
    .calibReq  (calibReq),
    .manualStep(manualStep),
    .manualDir (manualDir),
    .alignOk   (alignOk),
    .irqClr    (irqClr),
    .occ       (occ),
    .cmd       (cmd),
    .irq       (irq),
    .calDone   (calDone),
    .fifoDelay (fifoDelay)
  );

  assign rdData  = cfgBypass ? wrData : rdDataQ;
  assign rdValid = cfgBypass ? 1'b1   : rdValidQ;
endmodule

// File: rtl/xclk_align_checks.sv
module xclk_align_checks #(
  parameter int AW   = 3,
  localparam int DLW = $clog2((1 << AW) + 1)
) (
  input logic           rdClk,
  input logic           rdRstN,
  input logic [1:0]     cfgMode,
  input logic           cfgBypass,
  input logic           calibReq,
  input logic           irqClr,
  input logic           rdValid,
  input logic           irq,
  input logic           calDone,
  input logic [DLW-1:0] fifoDelay
);
  AST_IDLE_UNTIL_CAL: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!calDone && !cfgBypass) |-> !rdValid);                                  // R2
  AST_CAL_TAKES: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (calibReq && !cfgBypass) |=> calDone);                                    // R2
  AST_DELAY_BOUND: assert property (@(posedge rdClk) disable iff (!rdRstN)
    fifoDelay <= DLW'(1 << AW));                                              // R2
  AST_NO_IRQ_MANUAL: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(irq) |-> ($past(cfgMode) == 2'd1 || $past(cfgMode) == 2'd2));       // R4
  AST_IRQ_STICKY: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (irq && !irqClr) |=> irq);                                                // R6
  AST_BYPASS_ZERO: assert property (@(posedge rdClk) disable iff (!rdRstN)
    cfgBypass |=> (!calDone && fifoDelay == '0));                             // R9
  AST_BYPASS_VALID: assert property (@(posedge rdClk) disable iff (!rdRstN)
    cfgBypass |-> rdValid);                                                   // R9
endmodule

bind xclk_align_fifo xclk_align_checks #(.AW(AW)) i_checks (.*);

// File: tb/test_xclk_align_fifo.sv
module test_xclk_align_fifo;
  localparam int DW = 16;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrRstN = 1'b0, rdRstN = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    cfgMode = 2'd0;
  logic          cfgBypass = 1'b0;
  logic [3:0]    cfgThresh = 4'd0;
  logic          calibReq = 1'b0, manualStep = 1'b0, manualDir = 1'b0;
  logic          alignOk = 1'b0, irqClr = 1'b0;
  logic [DW-1:0] rdData;
  logic          rdValid, irq, calDone;
  logic [3:0]    fifoDelay;

  int nChecks = 0, nFail = 0;
  bit monOn = 0, resync = 1, done = 0;
  logic [DW-1:0] sbQ [$];

  xclk_align_fifo i_xclk_align_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN),
    .cfgMode(cfgMode), .cfgBypass(cfgBypass), .cfgThresh(cfgThresh),
    .calibReq(calibReq), .manualStep(manualStep), .manualDir(manualDir),
    .alignOk(alignOk), .irqClr(irqClr),
    .rdData(rdData), .rdValid(rdValid), .irq(irq), .calDone(calDone),
    .fifoDelay(fifoDelay)
  );

  // 50 MHz converter clock, same-rate data clock with a 5 ns phase offset
  always #10 rdClk = ~rdClk;
  initial begin
    #5;
    forever #10 wrClk = ~wrClk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRd(input int n);
    for (int i = 0; i < n; i++) @(negedge rdClk);
  endtask

  task automatic pulseCal();
    calibReq = 1'b1; @(negedge rdClk); calibReq = 1'b0;
  endtask

  // returns rdData advance over four cycles around a one-cycle step pulse
  task automatic stepWindow(input bit dir, input bit doStep, output int diff);
    logic [DW-1:0] d0;
    d0 = rdData;
    manualDir = dir; manualStep = doStep;
    @(negedge rdClk); manualStep = 1'b0;
    waitRd(3);
    diff = int'(rdData - d0);
  endtask

  // driver: every written sample is an expected item
  initial begin
    forever begin
      @(posedge wrClk);
      if (wrRstN) begin
        sbQ.push_back(wrData);
        #1 wrData = wrData + 1'b1;
      end
    end
  end

  // monitor: compare each produced sample with the queue
  initial begin
    forever begin
      @(negedge rdClk);
      if (monOn && rdValid && !cfgBypass) begin
        if (resync) begin
          while (sbQ.size() > 0 && sbQ[0] != rdData) void'(sbQ.pop_front());
          if (sbQ.size() > 0) begin
            void'(sbQ.pop_front());
            resync = 0;
          end
        end else if (sbQ.size() == 0) begin
          check(0, "R3 queue empty", int'(rdData), -1);
        end else begin
          check(rdData == sbQ[0], "R3 sample order", int'(rdData), int'(sbQ[0]));
          void'(sbQ.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int diff;
    #103 wrRstN = 1'b1; rdRstN = 1'b1;
    @(negedge rdClk);
    check(rdValid == 0 && irq == 0 && calDone == 0, "R1 reset outputs", {rdValid, irq, calDone}, 0);
    check(fifoDelay == 0, "R1 reset delay", fifoDelay, 0);
    waitRd(10);
    check(rdValid == 0, "R2 no data before calibration", rdValid, 0);

    pulseCal();
    check(calDone == 1, "R2 calDone after request", calDone, 1);
    waitRd(8);
    check(fifoDelay == 4, "R2 centred delay", fifoDelay, 4);
    check(rdValid == 1, "R2 stream running", rdValid, 1);
    resync = 1; monOn = 1;
    waitRd(40);

    // R4 manual steps
    monOn = 0;
    stepWindow(1'b1, 1'b1, diff);
    check(diff == 5, "R4 skip drops one sample", diff, 5);
    waitRd(6);
    check(fifoDelay == 3, "R4 skip lowers delay", fifoDelay, 3);
    stepWindow(1'b0, 1'b1, diff);
    check(diff == 3, "R4 hold repeats one sample", diff, 3);
    waitRd(6);
    check(fifoDelay == 4, "R4 hold raises delay", fifoDelay, 4);
    stepWindow(1'b1, 1'b1, diff);
    stepWindow(1'b1, 1'b1, diff);
    waitRd(20);
    check(fifoDelay == 2, "R4 two skips", fifoDelay, 2);
    check(irq == 0, "R4 manual never interrupts", irq, 0);

    // R5 average within threshold: sum -8, limit 12
    resync = 1; monOn = 1;
    cfgMode = 2'd1; cfgThresh = 4'd3;
    waitRd(20);
    check(irq == 0, "R5 below threshold no irq", irq, 0);

    // R6 surveillance
    cfgThresh = 4'd0;
    stepWindow(1'b0, 1'b0, diff);
    check(diff == 4, "R6 stream untouched", diff, 4);
    waitRd(10);
    check(irq == 1, "R6 violation raises irq", irq, 1);
    check(fifoDelay == 2, "R6 pointer untouched", fifoDelay, 2);
    cfgThresh = 4'd3;
    waitRd(10);
    check(irq == 1, "R6 irq sticky", irq, 1);
    irqClr = 1'b1; @(negedge rdClk); irqClr = 1'b0;
    waitRd(2);
    check(irq == 0, "R6 irq cleared", irq, 0);

    // R8 automatic without alignment permission
    cfgMode = 2'd2; cfgThresh = 4'd0; alignOk = 1'b0;
    waitRd(10);
    stepWindow(1'b0, 1'b0, diff);
    check(diff == 4, "R8 no drop or repeat", diff, 4);
    waitRd(10);
    check(irq == 1, "R8 violation raises irq", irq, 1);
    check(fifoDelay == 2, "R8 no pointer step", fifoDelay, 2);

    // R7 automatic correction
    monOn = 0;
    alignOk = 1'b1;
    waitRd(30);
    check(fifoDelay == 4, "R7 recentred", fifoDelay, 4);
    irqClr = 1'b1; @(negedge rdClk); irqClr = 1'b0;
    waitRd(12);
    check(irq == 0, "R7 no irq once centred", irq, 0);
    alignOk = 1'b0;
    resync = 1; monOn = 1;
    waitRd(20);

    // R10 recalibration
    monOn = 0;
    cfgMode = 2'd0;
    stepWindow(1'b1, 1'b1, diff);
    stepWindow(1'b1, 1'b1, diff);
    waitRd(8);
    check(fifoDelay == 2, "R10 offset before recal", fifoDelay, 2);
    pulseCal();
    waitRd(8);
    check(fifoDelay == 4, "R10 recal recentres", fifoDelay, 4);
    resync = 1; monOn = 1;
    waitRd(20);

    // R9 bypass
    monOn = 0;
    cfgBypass = 1'b1;
    @(negedge rdClk);
    check(calDone == 0, "R9 bypass clears calDone", calDone, 0);
    check(fifoDelay == 0, "R9 bypass delay zero", fifoDelay, 0);
    for (int i = 0; i < 4; i++) begin
      check(rdData == wrData, "R9 straight through", int'(rdData), int'(wrData));
      check(rdValid == 1, "R9 valid in bypass", rdValid, 1);
      @(negedge rdClk);
    end
    cfgBypass = 1'b0;
    waitRd(5);
    check(rdValid == 0, "R9 needs recal after bypass", rdValid, 0);
    pulseCal();
    waitRd(8);
    check(fifoDelay == 4, "R9 recal after bypass", fifoDelay, 4);
    resync = 1; monOn = 1;
    waitRd(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule